// File: doc/BRIEF.md
# Gate Pulse Modulator Controller

This block is the digital sequencer behind a panel gate-voltage switch. Each clock cycle it chooses which analog switch drives the gate output: ground, the high rail, the low reference (slewing), or no switch at all. The choice depends on a supply undervoltage flag, a panel reset flag, a timing-control input from the display controller, and a flag that reports whether the high rail is still above 3 V. The capacitor-timed delays of an analog implementation are replaced by clock counters.

After the supply leaves undervoltage, an internal power-on counter must expire before the controller leaves the ground state. In normal operation the output follows the timing-control input. A rising edge selects the high rail at once. A falling edge starts a programmable delay that ends in the slewing low-reference state. A strap removes this delay. At power-down the output is held at the high rail while that rail is valid. Once the rail drops, the output is released.

Top module: `gpm_ctrl`

## Requirements
- R1: While `rst_n` is low, `sel` is 3'b000, and `slewing` and `drive_en` are 0.
- R2: `drive_en` rises only after `uvlo` has been low for `PON_CYCLES` consecutive clock edges. Any cycle with `uvlo` high clears it on the next edge.
- R3: With `uvlo` low and `drive_en` low, `sel` is 3'b001 (ground) one edge later.
- R4: With `drive_en` high, `panel_rst_n` high and `flk` high, `sel` is 3'b010 (high rail) one edge later. The rising transition has no added delay.
- R5: With a nonzero `fall_dly` = D and `zero_dly` low, a falling `flk` keeps `sel` at 3'b010 for D edges. On the next edge `sel` becomes 3'b100 (low reference) with `slewing` high.
- R6: When `zero_dly` is high or `fall_dly` is 0, `sel` becomes 3'b100 one edge after `flk` is seen low.
- R7: If `flk` rises during the delay, the delay is abandoned, and `sel` is 3'b010 one edge later and stays there.
- R8: While `uvlo` is high, `sel` is 3'b010 if `rail_hi_ok` is high and 3'b000 (undriven) otherwise, one edge later. This takes priority over every other input.
- R9: With `uvlo` low, `drive_en` high and `panel_rst_n` low, `sel` is 3'b010 if `rail_hi_ok` is high and 3'b001 otherwise, one edge later.
- R10: `sel` has at most one bit set in every cycle, and `slewing` is high only while `sel` is 3'b100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| uvlo | input | 1 | Supply is below its undervoltage threshold |
| flk | input | 1 | Timing-control input from the display controller |
| panel_rst_n | input | 1 | Panel reset flag, high when released |
| rail_hi_ok | input | 1 | High rail is above 3 V |
| zero_dly | input | 1 | Strap that removes the falling-edge delay |
| fall_dly | input | DLY_W | Falling-edge delay in clock cycles |
| sel | output | 3 | Switch select: bit0 ground, bit1 high rail, bit2 low reference |
| slewing | output | 1 | Output is being pulled toward the low reference |
| drive_en | output | 1 | Power-on delay has expired |

## Verification
A wrong state register appears on `sel` at the very next edge, because the select is a pure decode of that state. The delay counter is different. An early or late expiry shows only as the cycle in which `sel` moves from the high rail to the low reference, so the bench samples both the cycle before and the cycle of that move. A power-on counter off by one shows as `drive_en` one cycle early or late, and the bench checks both neighbouring cycles.

// File: rtl/gpm_pkg.sv
package gpm_pkg;
  typedef enum logic [2:0] {
    ST_FLOAT = 3'd0,
    ST_GND   = 3'd1,
    ST_HI    = 3'd2,
    ST_WAIT  = 3'd3,
    ST_LO    = 3'd4
  } gpm_state_e;

  localparam logic [2:0] SEL_NONE = 3'b000;
  localparam logic [2:0] SEL_GND  = 3'b001;
  localparam logic [2:0] SEL_HI   = 3'b010;
  localparam logic [2:0] SEL_LO   = 3'b100;

  function automatic logic [2:0] state_to_sel(input gpm_state_e st);
    case (st)
      ST_GND:          return SEL_GND;
      ST_HI, ST_WAIT:  return SEL_HI;
      ST_LO:           return SEL_LO;
      default:         return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/gpm_pwr_seq.sv
module gpm_pwr_seq #(
  parameter int PON_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uvlo,
  output logic pon_done
);
  localparam int CW = $clog2(PON_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(PON_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || uvlo) cnt <= '0;
    else if (cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign pon_done = (cnt == LIMIT);
endmodule

// File: rtl/gpm_fall_timer.sv
module gpm_fall_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DLY_W-1:0] limit,
  output logic             done
);
  logic [DLY_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (!done) cnt <= cnt + 1'b1;
  end

  assign done = run && (cnt == (limit - DLY_W'(1)));
endmodule

// File: rtl/gpm_ctrl.sv
module gpm_ctrl #(
  parameter int PON_CYCLES = 16,
  parameter int DLY_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             uvlo,
  input  logic             flk,
  input  logic             panel_rst_n,
  input  logic             rail_hi_ok,
  input  logic             zero_dly,
  input  logic [DLY_W-1:0] fall_dly,
  output logic [2:0]       sel,
  output logic             slewing,
  output logic             drive_en
);
  import gpm_pkg::*;

  gpm_state_e state, state_nx;
  logic       timer_run;
  logic       timer_done;
  logic       skip_delay;

  gpm_pwr_seq #(.PON_CYCLES(PON_CYCLES)) u_pwr (
    .clk(clk), .rst_n(rst_n), .uvlo(uvlo), .pon_done(drive_en)
  );

  assign timer_run = (state == ST_WAIT);

  gpm_fall_timer #(.DLY_W(DLY_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(timer_run), .limit(fall_dly), .done(timer_done)
  );

  assign skip_delay = zero_dly || (fall_dly == '0);

  always_comb begin
    state_nx = state;
    if (uvlo)              state_nx = rail_hi_ok ? ST_HI : ST_FLOAT;
    else if (!drive_en)    state_nx = ST_GND;
    else if (!panel_rst_n) state_nx = rail_hi_ok ? ST_HI : ST_GND;
    else if (flk)          state_nx = ST_HI;
    else begin
      case (state)
        ST_HI:   state_nx = skip_delay ? ST_LO : ST_WAIT;
        ST_WAIT: state_nx = timer_done ? ST_LO : ST_WAIT;
        default: state_nx = ST_LO;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_FLOAT;
    else        state <= state_nx;
  end

  assign sel     = state_to_sel(state);
  assign slewing = (state == ST_LO);
endmodule

// File: rtl/gpm_chk.sv
module gpm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       uvlo,
  input logic       flk,
  input logic       panel_rst_n,
  input logic       rail_hi_ok,
  input logic       drive_en,
  input logic       timer_done,
  input logic [2:0] sel,
  input logic       slewing
);
  // R10
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(sel));
  // R10
  slew_on_lo_chk: assert property (@(posedge clk) disable iff (!rst_n) slewing |-> sel == 3'b100);
  // R8
  uv_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uvlo && !rail_hi_ok) |=> sel == 3'b000);
  // R8
  uv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uvlo && rail_hi_ok) |=> sel == 3'b010);
  // R3
  pre_en_gnd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!uvlo && !drive_en) |=> sel == 3'b001);
  // R4
  rise_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!uvlo && drive_en && panel_rst_n && flk) |=> sel == 3'b010);
  // R5
  expire_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!uvlo && drive_en && panel_rst_n && !flk && timer_done) |=> (sel == 3'b100 && slewing));
  // R2
  en_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_en) |-> !$past(uvlo));
  // R2
  uv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) uvlo |=> !drive_en);
endmodule

bind gpm_ctrl gpm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .uvlo(uvlo), .flk(flk), .panel_rst_n(panel_rst_n),
  .rail_hi_ok(rail_hi_ok), .drive_en(drive_en), .timer_done(timer_done),
  .sel(sel), .slewing(slewing)
);

// File: tb/tb_gpm_ctrl.sv
module tb_gpm_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int PON = 16;
  localparam int DW  = 8;

  logic clk = 0;
  logic rst_n = 0;
  logic uvlo = 1, flk = 1, panel_rst_n = 1, rail_hi_ok = 1, zero_dly = 0;
  logic [DW-1:0] fall_dly = 8'd5;
  logic [2:0] sel;
  logic slewing, drive_en;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpm_ctrl #(.PON_CYCLES(PON), .DLY_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .uvlo(uvlo), .flk(flk), .panel_rst_n(panel_rst_n),
    .rail_hi_ok(rail_hi_ok), .zero_dly(zero_dly), .fall_dly(fall_dly),
    .sel(sel), .slewing(slewing), .drive_en(drive_en)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [2:0] exp_sel, input logic exp_slew);
    n_chk++;
    if (sel !== exp_sel || slewing !== exp_slew || !$onehot0(sel)) begin
      n_fail++;
      $display("FAIL %s: sel=%b slewing=%b expected sel=%b slewing=%b", req, sel, slewing, exp_sel, exp_slew);
    end
  endtask

  task automatic chk_en(input string req, input logic exp);
    n_chk++;
    if (drive_en !== exp) begin
      n_fail++;
      $display("FAIL %s: drive_en=%b expected %b", req, drive_en, exp);
    end
  endtask

  task automatic t_reset;
    tick(2);
    chk("R1", 3'b000, 0);
    chk_en("R1", 0);
    rst_n = 1;
  endtask

  task automatic t_undervoltage;
    uvlo = 1; rail_hi_ok = 1; tick(1);
    chk("R8", 3'b010, 0);
    rail_hi_ok = 0; tick(1);
    chk("R8", 3'b000, 0);
  endtask

  task automatic t_power_on;
    uvlo = 0; rail_hi_ok = 1; flk = 1; panel_rst_n = 1;
    tick(PON - 1);
    chk_en("R2", 0);
    chk("R3", 3'b001, 0);
    tick(1);
    chk_en("R2", 1);
    tick(1);
    chk("R4", 3'b010, 0);
  endtask

  task automatic t_delayed_fall;
    fall_dly = 8'd5; zero_dly = 0; flk = 0;
    tick(5);
    chk("R5", 3'b010, 0);
    tick(1);
    chk("R5", 3'b100, 1);
    flk = 1; tick(1);
    chk("R4", 3'b010, 0);
  endtask

  task automatic t_cancel;
    flk = 0; tick(2);
    flk = 1; tick(1);
    chk("R7", 3'b010, 0);
    tick(6);
    chk("R7", 3'b010, 0);
  endtask

  task automatic t_zero_delay;
    zero_dly = 1; flk = 0; tick(1);
    chk("R6", 3'b100, 1);
    zero_dly = 0; flk = 1; tick(1);
    fall_dly = 8'd0; flk = 0; tick(1);
    chk("R6", 3'b100, 1);
    flk = 1; fall_dly = 8'd5; tick(1);
    chk("R4", 3'b010, 0);
  endtask

  task automatic t_panel_reset;
    flk = 0; panel_rst_n = 0; tick(1);
    chk("R9", 3'b010, 0);
    rail_hi_ok = 0; tick(1);
    chk("R9", 3'b001, 0);
    rail_hi_ok = 1; panel_rst_n = 1; flk = 1; tick(1);
    chk("R4", 3'b010, 0);
  endtask

  task automatic t_power_down;
    uvlo = 1; flk = 0; tick(1);
    chk_en("R2", 0);
    chk("R8", 3'b010, 0);
    rail_hi_ok = 0; tick(1);
    chk("R8", 3'b000, 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_undervoltage();
        t_power_on();
        t_delayed_fall();
        t_cancel();
        t_zero_delay();
        t_panel_reset();
        t_power_down();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule